// File: doc/BRIEF.md
# Synthesizer Configuration Word Loader

This block receives the 40-bit configuration word of a direct digital synthesizer core and holds the settings the core runs with. The word is split into five byte slots. Slot 0 carries a 5-bit phase offset, a power-down flag, a serial-request bit and a clock-multiplier enable. Slots 1 to 4 carry the 32-bit frequency tuning word, most significant byte first. The word is staged in one of two ways. In parallel mode each write strobe stores one byte from an 8-bit bus into the next slot, in a fixed order that cannot be addressed directly. In serial mode each write strobe shifts one bit in from a single data pin.

Staged contents do not affect the core until an update strobe copies them into the active registers. The update strobe also sends the slot pointer back to slot 0. The block starts in parallel mode. It switches to serial mode when an update applies a slot 0 whose serial-request bit is set, and it stays in serial mode until reset. All inputs are sampled on one system clock. The write and update strobes are one-cycle enables on that clock.

Top module: `dds_cfg_loader`

## Requirements
- R1: In parallel mode, five write strobes store bytes into slot 0 to slot 4 in that order. After an update, `phase_off` equals slot 0 bits 7:3, `pwr_down` equals slot 0 bit 2 and `mult_en` equals slot 0 bit 0. `tuning_word` equals {slot 1, slot 2, slot 3, slot 4}, so slot 1 supplies bits 31:24.
- R2: The outputs `tuning_word`, `phase_off`, `pwr_down` and `mult_en` change only in the cycle after an update strobe. Staged writes are not visible before that update.
- R3: In parallel mode, write strobes after slot 4 has been filled, and before the next update, are ignored. The staged slots keep their values.
- R4: An update strobe returns the slot pointer to slot 0, so the next parallel write lands in slot 0.
- R5: Slots not written since the last update keep their staged values. Writing only slot 0 and then updating leaves `tuning_word` unchanged.
- R6: A write strobe in the same cycle as an update strobe is dropped. The update applies the contents staged before that cycle.
- R7: An update in parallel mode whose staged slot 0 has bit 1 set drives `serial_mode` high from the next cycle.
- R8: In serial mode, each write strobe shifts `ser_bit` into the 40-bit staged word. The first of 40 bits ends up as tuning-word bit 0 and the last ends up as phase-offset bit 4, which is slot 0 bit 7.
- R9: Once set, `serial_mode` stays high until reset, even after a slot 0 with bit 1 clear has been applied. While it is high, `par_byte` has no effect.
- R10: A synchronous active-low reset clears the active outputs and the staged word, returns the pointer to slot 0 and selects parallel mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_stb | input | 1 | Write strobe, one byte or one bit per cycle |
| par_byte | input | 8 | Parallel byte bus |
| ser_bit | input | 1 | Serial data pin |
| upd_stb | input | 1 | Update strobe, copies the staged word to the outputs |
| tuning_word | output | 32 | Active frequency tuning word |
| phase_off | output | 5 | Active phase offset |
| pwr_down | output | 1 | Active power-down flag |
| mult_en | output | 1 | Active clock-multiplier enable |
| serial_mode | output | 1 | High once serial loading is selected |

## Verification
A wrong slot pointer cannot be seen until the next update. It then shows as a byte in the wrong field of `tuning_word` or `phase_off`, one cycle after the strobe. A reversed or misaligned serial shift shows the same way, one cycle after the update that follows 40 shifts. The bench therefore compares every field after every update, for both random sequences and directed ones. A mode flag that is wrong shows at once on `serial_mode`. It also shows after the next update, when parallel bytes are seen to have leaked into the word.

// File: rtl/dds_cfg_pkg.sv
// Package: shared sizes for the synthesizer configuration loader.
// Assumes slot 0 holds the control byte and the remaining slots hold the
// tuning word, most significant byte first.
package dds_cfg_pkg;
    localparam int BYTE_W   = 8;
    localparam int N_SLOTS  = 5;
    // Bit positions inside slot 0 (fixed by the core that decodes them)
    localparam int CTL_MULT = 0;
    localparam int CTL_SER  = 1;
    localparam int CTL_PDN  = 2;
    localparam int PH_LSB   = 3;
endpackage

// File: rtl/dds_stage_reg.sv
// Module: staging register for the configuration word.
// In parallel mode, each write stores the byte into the slot the internal
// pointer selects, and the pointer then advances. It stops after the last slot.
// In serial mode, each write shifts one bit in at the top, so the first bit
// ends up at bit 0 after a full word.
// Assumes an update and a write in the same cycle: the write is dropped.
module dds_stage_reg #(
    parameter int BYTE_W  = dds_cfg_pkg::BYTE_W,
    parameter int N_SLOTS = dds_cfg_pkg::N_SLOTS,
    localparam int TOT_W  = BYTE_W * N_SLOTS,
    localparam int PTR_W  = $clog2(N_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] par_byte,
    input  logic              ser_bit,
    input  logic              upd_stb,
    input  logic              ser_mode,
    output logic [TOT_W-1:0]  stg_word
);
    logic [TOT_W-1:0] stg_q, stg_d;
    logic [PTR_W-1:0] ptr_q;
    logic             par_wr;

    assign par_wr = wr_stb && !upd_stb && !ser_mode && (ptr_q < PTR_W'(N_SLOTS));

    // Next staged word: a serial shift, or one slot replaced by the bus byte
    always_comb begin
        stg_d = stg_q;
        if (wr_stb && !upd_stb && ser_mode) begin
            stg_d = {ser_bit, stg_q[TOT_W-1:1]};
        end else if (par_wr) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                if (ptr_q == PTR_W'(i))
                    stg_d[(N_SLOTS-1-i)*BYTE_W +: BYTE_W] = par_byte;
            end
        end
    end

    // Register the staged word and the slot pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
            ptr_q <= '0;
        end else begin
            stg_q <= stg_d;
            if (upd_stb)
                ptr_q <= '0;
            else if (par_wr)
                ptr_q <= ptr_q + PTR_W'(1);
        end
    end

    assign stg_word = stg_q;

    // The pointer never passes the stop position after the last slot
    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_W'(N_SLOTS));

    // An update sends the pointer back to slot 0
    assert_ptr_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> (ptr_q == '0));

    // Writes past the last slot leave the staged word untouched
    assert_overflow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !upd_stb && !ser_mode && ptr_q == PTR_W'(N_SLOTS)) |=> $stable(stg_q));
endmodule

// File: rtl/dds_field_split.sv
// Module: splits the staged word into its fields.
// Assumes slot 0 is the top byte and the tuning word is the lower slots.
module dds_field_split #(
    parameter int BYTE_W  = dds_cfg_pkg::BYTE_W,
    parameter int N_SLOTS = dds_cfg_pkg::N_SLOTS,
    localparam int TOT_W  = BYTE_W * N_SLOTS,
    localparam int FTW_W  = BYTE_W * (N_SLOTS - 1),
    localparam int PH_W   = BYTE_W - dds_cfg_pkg::PH_LSB
) (
    input  logic [TOT_W-1:0] word,
    output logic [FTW_W-1:0] ftw,
    output logic [PH_W-1:0]  phase,
    output logic             pdn,
    output logic             ser_req,
    output logic             mult
);
    logic [BYTE_W-1:0] ctl;

    // Pick the control byte and its fields
    always_comb begin
        ctl     = word[TOT_W-1 -: BYTE_W];
        ftw     = word[FTW_W-1:0];
        phase   = ctl[BYTE_W-1:dds_cfg_pkg::PH_LSB];
        pdn     = ctl[dds_cfg_pkg::CTL_PDN];
        ser_req = ctl[dds_cfg_pkg::CTL_SER];
        mult    = ctl[dds_cfg_pkg::CTL_MULT];
    end
endmodule

// File: rtl/dds_active_reg.sv
// Module: active configuration registers and the loading-mode flag.
// Loads every field on an update. Sets the serial flag when an update in
// parallel mode carries the serial request. Only reset clears the flag.
module dds_active_reg #(
    parameter int FTW_W = 32,
    parameter int PH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_stb,
    input  logic [FTW_W-1:0] s_ftw,
    input  logic [PH_W-1:0]  s_phase,
    input  logic             s_pdn,
    input  logic             s_ser_req,
    input  logic             s_mult,
    output logic [FTW_W-1:0] ftw,
    output logic [PH_W-1:0]  phase,
    output logic             pdn,
    output logic             mult,
    output logic             ser_mode
);
    // Copy the staged fields on an update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw   <= '0;
            phase <= '0;
            pdn   <= 1'b0;
            mult  <= 1'b0;
        end else if (upd_stb) begin
            ftw   <= s_ftw;
            phase <= s_phase;
            pdn   <= s_pdn;
            mult  <= s_mult;
        end
    end

    // Sticky serial-mode flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            ser_mode <= 1'b0;
        else if (upd_stb && s_ser_req)
            ser_mode <= 1'b1;
    end

    // Outputs hold unless an update occurred
    assert_outputs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |=> $stable({ftw, phase, pdn, mult}));

    // Serial request applied in parallel mode enters serial mode
    assert_serial_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && upd_stb && s_ser_req) |=> ser_mode);

    // Serial mode is left only through reset
    assert_serial_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_mode |=> ser_mode);
endmodule

// File: rtl/dds_cfg_loader.sv
// Module: top of the configuration word loader.
// Connects the staging register, the field split and the active registers.
// All strobes are one-cycle enables on clk.
module dds_cfg_loader #(
    parameter int BYTE_W  = dds_cfg_pkg::BYTE_W,
    parameter int N_SLOTS = dds_cfg_pkg::N_SLOTS,
    localparam int TOT_W  = BYTE_W * N_SLOTS,
    localparam int FTW_W  = BYTE_W * (N_SLOTS - 1),
    localparam int PH_W   = BYTE_W - dds_cfg_pkg::PH_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] par_byte,
    input  logic              ser_bit,
    input  logic              upd_stb,
    output logic [FTW_W-1:0]  tuning_word,
    output logic [PH_W-1:0]   phase_off,
    output logic              pwr_down,
    output logic              mult_en,
    output logic              serial_mode
);
    logic [TOT_W-1:0] stg_word;
    logic [FTW_W-1:0] s_ftw;
    logic [PH_W-1:0]  s_phase;
    logic             s_pdn, s_ser_req, s_mult;

    dds_stage_reg #(.BYTE_W(BYTE_W), .N_SLOTS(N_SLOTS)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .par_byte(par_byte),
        .ser_bit(ser_bit), .upd_stb(upd_stb), .ser_mode(serial_mode),
        .stg_word(stg_word)
    );

    dds_field_split #(.BYTE_W(BYTE_W), .N_SLOTS(N_SLOTS)) u_split (
        .word(stg_word), .ftw(s_ftw), .phase(s_phase), .pdn(s_pdn),
        .ser_req(s_ser_req), .mult(s_mult)
    );

    dds_active_reg #(.FTW_W(FTW_W), .PH_W(PH_W)) u_active (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .s_ftw(s_ftw),
        .s_phase(s_phase), .s_pdn(s_pdn), .s_ser_req(s_ser_req),
        .s_mult(s_mult), .ftw(tuning_word), .phase(phase_off),
        .pdn(pwr_down), .mult(mult_en), .ser_mode(serial_mode)
    );

    // Reset leaves every output cleared on the next cycle
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (tuning_word == '0 && phase_off == '0 && !pwr_down &&
                    !mult_en && !serial_mode));
endmodule

// File: tb/tb_dds_cfg_loader.sv
module tb_dds_cfg_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  par_byte = '0;
    logic        ser_bit = 1'b0;
    logic        upd_stb = 1'b0;
    logic [31:0] tuning_word;
    logic [4:0]  phase_off;
    logic        pwr_down, mult_en, serial_mode;

    int n_chk = 0;
    int n_err = 0;

    // Bench model: staged and active 40-bit words, slot 0 in bits 39:32
    logic [39:0] m_stg, m_act;
    int          m_ptr;
    bit          m_ser;

    always #2 clk = ~clk;   // 250 MHz

    dds_cfg_loader dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .par_byte(par_byte),
        .ser_bit(ser_bit), .upd_stb(upd_stb), .tuning_word(tuning_word),
        .phase_off(phase_off), .pwr_down(pwr_down), .mult_en(mult_en),
        .serial_mode(serial_mode)
    );

    task automatic chk(input string tag);
        logic [39:0] got;
        @(negedge clk);
        n_chk++;
        got = {phase_off, pwr_down, 1'b0, mult_en, tuning_word};
        if (got != {m_act[39:34], 1'b0, m_act[32:0]} || serial_mode != m_ser) begin
            n_err++;
            $display("FAIL %s: got word=%h ser=%0b expected word=%h ser=%0b", tag,
                     got, serial_mode, {m_act[39:34], 1'b0, m_act[32:0]}, m_ser);
        end
    endtask

    task automatic step(input bit wr, input logic [7:0] b, input bit sb, input bit up);
        @(negedge clk);
        wr_stb = wr; par_byte = b; ser_bit = sb; upd_stb = up;
        @(posedge clk);
        #1;
        if (up) begin
            m_act = m_stg;
            m_ptr = 0;
            if (m_stg[33]) m_ser = 1'b1;
        end else if (wr) begin
            if (m_ser) m_stg = {sb, m_stg[39:1]};
            else if (m_ptr < 5) begin
                m_stg[39-8*m_ptr -: 8] = b;
                m_ptr++;
            end
        end
        wr_stb = 1'b0; upd_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        m_stg = '0; m_act = '0; m_ptr = 0; m_ser = 1'b0;
    endtask

    task automatic shift_word(input logic [39:0] v);
        for (int i = 0; i < 40; i++) step(1'b1, 8'($urandom), v[i], 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        chk("R10 reset state");

        // Directed five-byte load
        step(1, 8'h09, 0, 0); step(1, 8'h0E, 0, 0); step(1, 8'h38, 0, 0);
        step(1, 8'hE3, 0, 0); step(1, 8'h8E, 0, 0);
        chk("R2 staged bytes not visible");
        step(0, 0, 0, 1);
        chk("R1 five-byte load");

        // Overflow writes ignored
        for (int i = 0; i < 7; i++) step(1, 8'($urandom) & 8'hFD, 0, 0);
        step(0, 0, 0, 1);
        chk("R3 writes after slot 4 ignored");

        // Slot 0 only
        step(1, 8'hA5 & 8'hFD, 0, 0); step(0, 0, 0, 1);
        chk("R5 slot 0 only keeps tuning word");
        step(1, 8'h50, 0, 0); step(0, 0, 0, 1);
        chk("R4 pointer back at slot 0");

        // Write together with update
        step(1, 8'h11, 0, 0); step(1, 8'hF8, 0, 1);
        chk("R6 write with update dropped");
        step(1, 8'h60, 0, 0); step(0, 0, 0, 1);
        chk("R6 pointer at slot 0 after dropped write");

        // Random parallel sequences
        for (int r = 0; r < 200; r++) begin
            int n = $urandom_range(0, 7);
            for (int k = 0; k < n; k++) step(1, 8'($urandom) & 8'hFD, 0, 0);
            step(0, 0, 0, 1);
            chk("R1 R3 R5 random parallel");
        end

        // Serial entry
        step(1, 8'h02, 0, 0); step(0, 0, 0, 1);
        chk("R7 serial mode entered");

        shift_word(40'h5A_1234_5678 & ~40'h02_0000_0000);
        chk("R2 serial bits not visible");
        step(0, 0, 0, 1);
        chk("R8 serial order");
        chk("R9 serial mode held with request bit clear");

        for (int r = 0; r < 10; r++) begin
            shift_word({8'($urandom), 32'($urandom)});
            step(0, 0, 0, 1);
            chk("R8 R9 random serial");
        end

        do_reset();
        chk("R10 reset leaves serial mode");
        step(1, 8'hC9, 0, 0); step(0, 0, 0, 1);
        chk("R10 parallel load after reset");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule